// File: doc/BRIEF.md
# Memory-Ordering Fence Sequencer

This block wraps a single memory operation with the fences its ordering semantics call for. A caller presents the kind of operation (load, store or atomic read-modify-write), a memory-order code, a segment code and a global switch for separate acquire/release handling, and pulses `start`. The sequencer then drives a fence port and a main-access port in the right order. It ends with a one-cycle completion pulse.

A release fence goes in front of any store or atomic that carries release semantics. An acquire fence follows any load or atomic that carries acquire semantics. Fences are skipped for the local scratchpad segment, for orders without acquire or release meaning, and whenever the global switch is off. Each fence is one request held until its single done response arrives, not one request per lane. An illegal order or kind code is reported through an error flag on the completion pulse, and no fence or access is issued for it.

Top module: `ordering_fence_seq`

## Requirements
- R1: Under reset and in the first cycle after it, `fence_req`, `fence_acq`, `acc_req`, `seq_done` and `seq_err` are all 0.
- R2: Order codes are 0 none, 1 relaxed, 2 acquire, 3 release, 4 acquire-release. Codes 5 to 7 and kind code 3 are illegal: no fence or access is issued, and `seq_done` and `seq_err` pulse together in the cycle after `start`.
- R3: For a store (kind 1) with order 3 or 4, a release fence (`fence_req`=1, `fence_acq`=0) is raised in the cycle after `start`. `acc_req` rises only in the cycle after `fence_done`. A store never gets an acquire fence.
- R4: For an atomic (kind 2) with order 3 or 4, a release fence comes before the access.
- R5: For a load (kind 0) with order 2 or 4, an acquire fence (`fence_req`=1, `fence_acq`=1) is raised in the cycle after `acc_done`. A load never gets a release fence.
- R6: For an atomic with order 2 or 4, an acquire fence follows the access. With order 4 the complete order is release fence, access, acquire fence.
- R7: When `seg_code` equals the parameter LOCAL_SEG (default 1), no fence is issued, whatever the order.
- R8: When `sep_en` is 0, the operation goes straight to the access with no fence.
- R9: Orders 0 and 1 produce no fence for any legal kind.
- R10: `fence_req` and `acc_req` are never high together. Each request is held until its done input is seen.
- R11: For each accepted operation, `seq_done` is high for exactly one cycle, in the cycle after the last phase completes.
- R12: `start` is ignored while a sequence is in progress or completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op_kind | input | OP_W | 0 load, 1 store, 2 atomic |
| mem_order | input | ORD_W | Memory-order code |
| seg_code | input | SEG_W | Segment code |
| sep_en | input | 1 | Enable separate acquire/release fences |
| fence_done | input | 1 | Fence completed |
| acc_done | input | 1 | Main access completed |
| fence_req | output | 1 | Fence request, held until done |
| fence_acq | output | 1 | 1 acquire fence, 0 release fence |
| acc_req | output | 1 | Main access request, held until done |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_err | output | 1 | Illegal code, valid with seq_done |

## Verification
The bench runs every combination of kind, order code, segment code and enable, which covers legal and illegal codes and local and non-local segments. It answers each request after a latency that changes from case to case, so stalled and immediate responses are both exercised. For each case it records the phases in the order they appear and compares them with the phase list worked out arithmetically. This separates release-before from acquire-after placement, shows the bypass cases, and shows the error exit. A directed case fires a second `start` during a fenced store to show that it is dropped.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACC  = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

  localparam int KIND_LOAD  = 0;
  localparam int KIND_STORE = 1;
  localparam int KIND_ATOM  = 2;

  localparam int ORDER_NONE = 0;
  localparam int ORDER_RLX  = 1;
  localparam int ORDER_ACQ  = 2;
  localparam int ORDER_REL  = 3;
  localparam int ORDER_AR   = 4;
endpackage

// File: rtl/ofs_plan.sv
module ofs_plan
  import ofs_pkg::*;
#(
  parameter int OP_W      = 2,
  parameter int ORD_W     = 3,
  parameter int SEG_W     = 2,
  parameter int LOCAL_SEG = 1
) (
  input  logic [OP_W-1:0]  op_kind,
  input  logic [ORD_W-1:0] mem_order,
  input  logic [SEG_W-1:0] seg_code,
  input  logic             sep_en,
  output logic             need_pre,
  output logic             need_post,
  output logic             bad_code
);
  logic kind_ok, order_ok, bypass, has_rel, has_acq, writes, reads;

  always_comb begin
    kind_ok  = (int'(op_kind) <= KIND_ATOM);
    order_ok = (int'(mem_order) <= ORDER_AR);
    bad_code = !(kind_ok && order_ok);
    bypass   = !sep_en || (int'(seg_code) == LOCAL_SEG);
    has_rel  = (int'(mem_order) == ORDER_REL) || (int'(mem_order) == ORDER_AR);
    has_acq  = (int'(mem_order) == ORDER_ACQ) || (int'(mem_order) == ORDER_AR);
    writes   = (int'(op_kind) == KIND_STORE) || (int'(op_kind) == KIND_ATOM);
    reads    = (int'(op_kind) == KIND_LOAD)  || (int'(op_kind) == KIND_ATOM);
    need_pre  = !bad_code && !bypass && writes && has_rel;
    need_post = !bad_code && !bypass && reads  && has_acq;
  end
endmodule

// File: rtl/ofs_fsm.sv
module ofs_fsm
  import ofs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic need_pre,
  input  logic need_post,
  input  logic bad_code,
  input  logic fence_done,
  input  logic acc_done,
  output logic fence_req,
  output logic fence_acq,
  output logic acc_req,
  output logic seq_done,
  output logic seq_err
);
  seq_state_t state, nxt;
  logic post_q, err_q, post_nxt, err_nxt;

  always_comb begin
    nxt      = state;
    post_q_hold: begin end
    post_nxt = post_q;
    err_nxt  = err_q;
    case (state)
      ST_IDLE: if (start) begin
        post_nxt = need_post;
        err_nxt  = bad_code;
        if (bad_code)      nxt = ST_DONE;
        else if (need_pre) nxt = ST_PRE;
        else               nxt = ST_ACC;
      end
      ST_PRE:  if (fence_done) nxt = ST_ACC;
      ST_ACC:  if (acc_done)   nxt = post_q ? ST_POST : ST_DONE;
      ST_POST: if (fence_done) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      post_q    <= 1'b0;
      err_q     <= 1'b0;
      fence_req <= 1'b0;
      fence_acq <= 1'b0;
      acc_req   <= 1'b0;
      seq_done  <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      state     <= nxt;
      post_q    <= post_nxt;
      err_q     <= err_nxt;
      fence_req <= (nxt == ST_PRE) || (nxt == ST_POST);
      fence_acq <= (nxt == ST_POST);
      acc_req   <= (nxt == ST_ACC);
      seq_done  <= (nxt == ST_DONE);
      seq_err   <= (nxt == ST_DONE) && err_nxt;
    end
  end
endmodule

// File: rtl/ordering_fence_seq.sv
module ordering_fence_seq #(
  parameter int OP_W      = 2,
  parameter int ORD_W     = 3,
  parameter int SEG_W     = 2,
  parameter int LOCAL_SEG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OP_W-1:0]  op_kind,
  input  logic [ORD_W-1:0] mem_order,
  input  logic [SEG_W-1:0] seg_code,
  input  logic             sep_en,
  input  logic             fence_done,
  input  logic             acc_done,
  output logic             fence_req,
  output logic             fence_acq,
  output logic             acc_req,
  output logic             seq_done,
  output logic             seq_err
);
  logic need_pre, need_post, bad_code;

  ofs_plan #(
    .OP_W(OP_W), .ORD_W(ORD_W), .SEG_W(SEG_W), .LOCAL_SEG(LOCAL_SEG)
  ) plan_i (
    .op_kind(op_kind), .mem_order(mem_order), .seg_code(seg_code),
    .sep_en(sep_en), .need_pre(need_pre), .need_post(need_post),
    .bad_code(bad_code)
  );

  ofs_fsm fsm_i (
    .clk(clk), .rst(rst), .start(start),
    .need_pre(need_pre), .need_post(need_post), .bad_code(bad_code),
    .fence_done(fence_done), .acc_done(acc_done),
    .fence_req(fence_req), .fence_acq(fence_acq), .acc_req(acc_req),
    .seq_done(seq_done), .seq_err(seq_err)
  );
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic fence_done,
  input logic acc_done,
  input logic fence_req,
  input logic fence_acq,
  input logic acc_req,
  input logic seq_done,
  input logic seq_err
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(fence_req || acc_req || seq_done || seq_err));

  // R10
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(fence_req && acc_req));

  // R10
  fence_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fence_req && !fence_done) |=> fence_req);

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_done) |=> acc_req);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  // R2
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> (seq_done && $past(start)));

  // R3
  rel_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    (fence_req && !fence_acq && !$past(fence_req)) |-> $past(start));

  // R5
  acq_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    (fence_req && fence_acq && !$past(fence_req)) |-> $past(acc_req && acc_done));
endmodule

bind ordering_fence_seq ofs_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .fence_done(fence_done),
  .acc_done(acc_done), .fence_req(fence_req), .fence_acq(fence_acq),
  .acc_req(acc_req), .seq_done(seq_done), .seq_err(seq_err)
);

// File: tb/ordering_fence_seq_tb_top.sv
module ordering_fence_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op_kind = '0;
  logic [2:0] mem_order = '0;
  logic [1:0] seg_code = '0;
  logic sep_en = 1'b0;
  logic fence_done = 1'b0;
  logic acc_done = 1'b0;
  logic fence_req, fence_acq, acc_req, seq_done, seq_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ordering_fence_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
    .mem_order(mem_order), .seg_code(seg_code), .sep_en(sep_en),
    .fence_done(fence_done), .acc_done(acc_done), .fence_req(fence_req),
    .fence_acq(fence_acq), .acc_req(acc_req), .seq_done(seq_done),
    .seq_err(seq_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (op=%0d ord=%0d seg=%0d en=%0d)",
               req, act, exp, op_kind, mem_order, seg_code, sep_en);
    end
  endtask

  // Phase trace codes: 1 release fence, 2 access, 3 acquire fence.
  task automatic run_case(input int op, input int ord, input int seg,
                          input int en, input int lat, input bit inject,
                          input string tag);
    int trace = 0, wt = 0, dones = 0, errv = 0, both = 0;
    bit prevf = 0, preva = 0, finished = 0;
    bit isbad, bypass, pre, post;
    int exp_trace = 0;
    isbad  = (ord > 4) || (op == 3);
    bypass = (en == 0) || (seg == 1);
    pre  = !isbad && !bypass && (op == 1 || op == 2) && (ord == 3 || ord == 4);
    post = !isbad && !bypass && (op == 0 || op == 2) && (ord == 2 || ord == 4);
    if (!isbad) begin
      if (pre) exp_trace = exp_trace * 4 + 1;
      exp_trace = exp_trace * 4 + 2;
      if (post) exp_trace = exp_trace * 4 + 3;
    end
    op_kind = 2'(op); mem_order = 3'(ord); seg_code = 2'(seg); sep_en = en[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 60 && !finished; c++) begin
      fence_done = 1'b0;
      acc_done = 1'b0;
      start = (inject && c == 1);
      if (inject && c == 1) begin op_kind = 2'd0; mem_order = 3'd2; end
      if (fence_req && acc_req) both = 1;
      if (fence_req) begin
        if (!prevf) begin trace = trace * 4 + (fence_acq ? 3 : 1); wt = 0; end
        else wt++;
        if (wt >= lat) fence_done = 1'b1;
      end
      if (acc_req) begin
        if (!preva) begin trace = trace * 4 + 2; wt = 0; end
        else wt++;
        if (wt >= lat) acc_done = 1'b1;
      end
      if (seq_done) begin dones++; errv = seq_err; end
      if (dones > 0 && !seq_done) finished = 1;
      prevf = fence_req;
      preva = acc_req;
      @(negedge clk);
    end
    start = 1'b0;
    fence_done = 1'b0;
    acc_done = 1'b0;
    check("R11 finished", int'(finished), 1);
    check("R11 done count", dones, 1);
    check({tag, " phase order"}, trace, exp_trace);
    check("R2 error flag", errv, int'(isbad));
    check("R10 exclusive", both, 0);
  endtask

  function automatic string tag_of(int op, int ord, int seg, int en);
    if (ord > 4 || op == 3) return "R2";
    if (en == 0) return "R8";
    if (seg == 1) return "R7";
    if (ord < 2) return "R9";
    if (op == 2 && ord == 4) return "R6";
    if (op == 2 && ord == 3) return "R4";
    if (op == 2) return "R6";
    if (op == 1) return "R3";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 fence_req", int'(fence_req), 0);
    check("R1 acc_req", int'(acc_req), 0);
    check("R1 seq_done", int'(seq_done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", int'(fence_req | acc_req | seq_done | seq_err | fence_acq), 0);

    for (int op = 0; op < 4; op++)
      for (int ord = 0; ord < 8; ord++)
        for (int seg = 0; seg < 4; seg++)
          for (int en = 0; en < 2; en++)
            run_case(op, ord, seg, en, (op + ord + seg) % 3, 1'b0,
                     tag_of(op, ord, seg, en));

    // R12: second start during a fenced store must be dropped
    run_case(1, 3, 0, 1, 3, 1'b1, "R12");
    for (int k = 0; k < 3; k++) begin
      check("R12 stays idle", int'(fence_req | acc_req | seq_done), 0);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule